// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs every architectural state change that happens when a 32-bit core takes a trap. It receives one trap request per cycle, with an interrupt flag, a cause code, the faulting address and the program counter of the trapping instruction. It decides whether the trap goes to the supervisor or to the machine level and rewrites an environment call into the form that matches the caller's privilege. It then loads the cause, exception PC and trap-value registers of the chosen level, stacks the interrupt-enable and previous-privilege fields in the status word, and moves to the new privilege. All of this is committed on a single clock edge.

On the same edge it sends the fetch unit a one-cycle redirect carrying the handler address, and a one-cycle pulse that drops any load reservation. The handler address comes from the target level's vector register, either direct or vectored by interrupt cause. A plain write port and a combinational read port let setup code and the bench reach every held register.

Top module: `trap_entry_seq`

## Requirements
- R1: A trap goes to supervisor level (privilege code 1) when the current privilege is user (0) or supervisor (1) and the delegation bit indexed by the effective cause is set. In every other case it goes to machine level (3), so a trap taken in machine mode always stays there. After the trap edge the privilege equals the target level.
- R2: Interrupts use the interrupt delegation mask (selector 2). Exceptions use the exception delegation mask (selector 1).
- R3: The status word has supervisor enable at bit 1, machine enable at bit 3, supervisor previous enable at bit 5, machine previous enable at bit 7, supervisor previous privilege at bit 8 (1 when the old privilege was not user), and machine previous privilege at bits 12:11. On a trap the target level's previous enable takes its old enable, its previous privilege takes the old privilege, and its enable is cleared. The other level's fields are unchanged.
- R4: The target level's cause register receives the effective cause in its low bits, with bit 31 set for interrupts and clear for exceptions.
- R5: The target level's exception PC register receives the trap PC input.
- R6: The target level's trap-value register receives the faulting address for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. It receives zero for every other exception and for all interrupts.
- R7: The handler address is the target level's vector register with bits 1:0 cleared.
- R8: When the vector register's bits 1:0 equal 1 and the trap is an interrupt, four times the cause is added to that base. Exceptions always use the base.
- R9: An exception with cause 8 becomes cause 8 from user, 9 from supervisor and 11 from machine. The rewritten value is the one used for delegation and stored in the cause register.
- R10: One cycle after a trap request, the redirect valid and reservation clear outputs are high for exactly one cycle, and the redirect address holds the handler address.
- R11: When a trap and a register write arrive in the same cycle, the write is discarded.
- R12: Register selectors are 0 status, 1 exception delegation, 2 interrupt delegation, 3 machine vector, 4 machine PC, 5 machine cause, 6 machine value, 7 supervisor vector, 8 supervisor PC, 9 supervisor cause, 10 supervisor value, and 11 privilege. A write takes effect on the next edge, with status storing only the bits of R3. Writing 2 to the privilege selects user.
- R13: After reset the privilege is machine, and all other registers and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | 5 | Raw cause code |
| trap_addr | input | 32 | Faulting address |
| trap_pc | input | 32 | PC of trapping instruction |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 4 | Write selector |
| csr_wdata | input | 32 | Write data |
| csr_rsel | input | 4 | Read selector |
| csr_rdata | output | 32 | Read data (combinational) |
| redirect_valid | output | 1 | Handler redirect pulse |
| redirect_pc | output | 32 | Handler address |
| resv_clear | output | 1 | Load reservation clear pulse |
| cur_priv | output | 2 | Current privilege |

## Verification
Every trap effect is due on the first rising edge after the request. Register writes follow the same timing, and readback is combinational. The bench drives inputs at the falling edge and checks the redirect outputs shortly after the next rising edge. It releases the request at the following falling edge, then walks the read selectors within that low phase. It checks the redirect outputs again one edge later to confirm they fall back to zero.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam logic [1:0] LVL_USER = 2'd0;
   localparam logic [1:0] LVL_SUPV = 2'd1;
   localparam logic [1:0] LVL_MACH = 2'd3;

   localparam logic [3:0] SEL_STATUS = 4'd0;
   localparam logic [3:0] SEL_EDELEG = 4'd1;
   localparam logic [3:0] SEL_IDELEG = 4'd2;
   localparam logic [3:0] SEL_MVEC   = 4'd3;
   localparam logic [3:0] SEL_MEPC   = 4'd4;
   localparam logic [3:0] SEL_MCAUSE = 4'd5;
   localparam logic [3:0] SEL_MTVAL  = 4'd6;
   localparam logic [3:0] SEL_SVEC   = 4'd7;
   localparam logic [3:0] SEL_SEPC   = 4'd8;
   localparam logic [3:0] SEL_SCAUSE = 4'd9;
   localparam logic [3:0] SEL_STVAL  = 4'd10;
   localparam logic [3:0] SEL_PRIV   = 4'd11;

   localparam int ST_SIE  = 1;
   localparam int ST_MIE  = 3;
   localparam int ST_SPIE = 5;
   localparam int ST_MPIE = 7;
   localparam int ST_SPP  = 8;
   localparam int ST_MPP  = 11;

   localparam int ECALL_BASE = 8;

   // Causes whose trap value is the faulting address
   function automatic logic cause_has_addr(input int unsigned c);
      case (c)
         0, 1, 4, 5, 6, 7, 12, 13, 15: return 1'b1;
         default:                      return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic               irq,
   input  logic [CAUSE_W-1:0] cause,
   input  logic [1:0]         priv,
   input  logic [XLEN-1:0]    edeleg,
   input  logic [XLEN-1:0]    ideleg,
   output logic [CAUSE_W-1:0] eff_cause,
   output logic               to_supv,
   output logic               keep_addr
);
   import trap_pkg::*;

   logic [XLEN-1:0] mask;

   always_comb begin
      eff_cause = cause;
      if (!irq && (int'(cause) == ECALL_BASE)) begin
         case (priv)
            LVL_USER: eff_cause = CAUSE_W'(ECALL_BASE);
            LVL_SUPV: eff_cause = CAUSE_W'(ECALL_BASE + 1);
            default:  eff_cause = CAUSE_W'(ECALL_BASE + 3);
         endcase
      end
      mask      = irq ? ideleg : edeleg;
      to_supv   = (priv != LVL_MACH) && mask[eff_cause];
      keep_addr = !irq && cause_has_addr(int'(eff_cause));
   end
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
   parameter int XLEN        = 32,
   parameter int CAUSE_W     = 5,
   parameter bit VECTORED_EN = 1'b1
) (
   input  logic [XLEN-1:0]    vec,
   input  logic               irq,
   input  logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    pc
);
   localparam int PAD = XLEN - CAUSE_W - 2;

   logic [XLEN-1:0] base;
   assign base = {vec[XLEN-1:2], 2'b00};

   generate
      if (VECTORED_EN) begin : g_vectored
         logic [XLEN-1:0] offs;
         assign offs = {{PAD{1'b0}}, cause, 2'b00};
         assign pc   = (irq && vec[1:0] == 2'b01) ? base + offs : base;
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = ^{irq, cause, vec[1:0]};
         assign pc        = base;
      end
   endgenerate
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
   parameter int XLEN        = 32,
   parameter int CAUSE_W     = 5,
   parameter bit VECTORED_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req,
   input  logic               trap_irq,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_addr,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic               csr_we,
   input  logic [3:0]         csr_sel,
   input  logic [XLEN-1:0]    csr_wdata,
   input  logic [3:0]         csr_rsel,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc,
   output logic               resv_clear,
   output logic [1:0]         cur_priv
);
   import trap_pkg::*;

   localparam int PAD = XLEN - 1 - CAUSE_W;

   generate
      if (CAUSE_W < 4 || (1 << CAUSE_W) > XLEN || XLEN < 16) begin : g_bad_cfg
         $error("trap_entry_seq: CAUSE_W must index a delegation mask of XLEN bits");
      end
   endgenerate

   logic [1:0]      priv_q;
   logic            sie_q, mie_q, spie_q, mpie_q, spp_q;
   logic [1:0]      mpp_q;
   logic [XLEN-1:0] edeleg_q, ideleg_q, mvec_q, svec_q;
   logic [XLEN-1:0] mepc_q, sepc_q, mcause_q, scause_q, mtval_q, stval_q;
   logic            redir_q, resv_q;
   logic [XLEN-1:0] redir_pc_q;

   logic [CAUSE_W-1:0] eff_cause;
   logic               to_supv, keep_addr;
   logic [XLEN-1:0]    tgt_vec, handler_pc, cause_word, tval_word;

   trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
      .irq      (trap_irq),
      .cause    (trap_cause),
      .priv     (priv_q),
      .edeleg   (edeleg_q),
      .ideleg   (ideleg_q),
      .eff_cause(eff_cause),
      .to_supv  (to_supv),
      .keep_addr(keep_addr)
   );

   assign tgt_vec = to_supv ? svec_q : mvec_q;

   trap_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTORED_EN(VECTORED_EN)) u_vec (
      .vec  (tgt_vec),
      .irq  (trap_irq),
      .cause(eff_cause),
      .pc   (handler_pc)
   );

   assign cause_word = {trap_irq, {PAD{1'b0}}, eff_cause};
   assign tval_word  = keep_addr ? trap_addr : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv_q     <= LVL_MACH;
         sie_q      <= 1'b0;
         mie_q      <= 1'b0;
         spie_q     <= 1'b0;
         mpie_q     <= 1'b0;
         spp_q      <= 1'b0;
         mpp_q      <= 2'b00;
         edeleg_q   <= '0;
         ideleg_q   <= '0;
         mvec_q     <= '0;
         svec_q     <= '0;
         mepc_q     <= '0;
         sepc_q     <= '0;
         mcause_q   <= '0;
         scause_q   <= '0;
         mtval_q    <= '0;
         stval_q    <= '0;
         redir_q    <= 1'b0;
         resv_q     <= 1'b0;
         redir_pc_q <= '0;
      end else begin
         redir_q <= trap_req;
         resv_q  <= trap_req;
         if (trap_req) begin
            redir_pc_q <= handler_pc;
            if (to_supv) begin
               spie_q   <= sie_q;
               spp_q    <= (priv_q != LVL_USER);
               sie_q    <= 1'b0;
               scause_q <= cause_word;
               sepc_q   <= trap_pc;
               stval_q  <= tval_word;
               priv_q   <= LVL_SUPV;
            end else begin
               mpie_q   <= mie_q;
               mpp_q    <= priv_q;
               mie_q    <= 1'b0;
               mcause_q <= cause_word;
               mepc_q   <= trap_pc;
               mtval_q  <= tval_word;
               priv_q   <= LVL_MACH;
            end
         end else if (csr_we) begin
            case (csr_sel)
               SEL_STATUS: begin
                  sie_q  <= csr_wdata[ST_SIE];
                  mie_q  <= csr_wdata[ST_MIE];
                  spie_q <= csr_wdata[ST_SPIE];
                  mpie_q <= csr_wdata[ST_MPIE];
                  spp_q  <= csr_wdata[ST_SPP];
                  mpp_q  <= csr_wdata[ST_MPP+1:ST_MPP];
               end
               SEL_EDELEG: edeleg_q <= csr_wdata;
               SEL_IDELEG: ideleg_q <= csr_wdata;
               SEL_MVEC:   mvec_q   <= csr_wdata;
               SEL_MEPC:   mepc_q   <= csr_wdata;
               SEL_MCAUSE: mcause_q <= csr_wdata;
               SEL_MTVAL:  mtval_q  <= csr_wdata;
               SEL_SVEC:   svec_q   <= csr_wdata;
               SEL_SEPC:   sepc_q   <= csr_wdata;
               SEL_SCAUSE: scause_q <= csr_wdata;
               SEL_STVAL:  stval_q  <= csr_wdata;
               SEL_PRIV:   priv_q   <= (csr_wdata[1:0] == 2'd2) ? LVL_USER : csr_wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      csr_rdata = '0;
      case (csr_rsel)
         SEL_STATUS: begin
            csr_rdata[ST_SIE]            = sie_q;
            csr_rdata[ST_MIE]            = mie_q;
            csr_rdata[ST_SPIE]           = spie_q;
            csr_rdata[ST_MPIE]           = mpie_q;
            csr_rdata[ST_SPP]            = spp_q;
            csr_rdata[ST_MPP+1:ST_MPP]   = mpp_q;
         end
         SEL_EDELEG: csr_rdata = edeleg_q;
         SEL_IDELEG: csr_rdata = ideleg_q;
         SEL_MVEC:   csr_rdata = mvec_q;
         SEL_MEPC:   csr_rdata = mepc_q;
         SEL_MCAUSE: csr_rdata = mcause_q;
         SEL_MTVAL:  csr_rdata = mtval_q;
         SEL_SVEC:   csr_rdata = svec_q;
         SEL_SEPC:   csr_rdata = sepc_q;
         SEL_SCAUSE: csr_rdata = scause_q;
         SEL_STVAL:  csr_rdata = stval_q;
         SEL_PRIV:   csr_rdata[1:0] = priv_q;
         default:    csr_rdata = '0;
      endcase
   end

   assign redirect_valid = redir_q;
   assign redirect_pc    = redir_pc_q;
   assign resv_clear     = resv_q;
   assign cur_priv       = priv_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trap_req,
   input logic            trap_irq,
   input logic [XLEN-1:0] trap_pc,
   input logic            to_supv,
   input logic [1:0]      priv_q,
   input logic            sie_q,
   input logic            mie_q,
   input logic            spie_q,
   input logic            mpie_q,
   input logic [1:0]      mpp_q,
   input logic [XLEN-1:0] mepc_q,
   input logic [XLEN-1:0] sepc_q,
   input logic [XLEN-1:0] mcause_q,
   input logic [XLEN-1:0] scause_q,
   input logic            redirect_valid,
   input logic            resv_clear
);
   a_r1_supv_target: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && to_supv |=> priv_q == 2'd1);
   a_r1_mach_target: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && !to_supv |=> priv_q == 2'd3);
   a_r1_mach_stays: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && priv_q == 2'd3 |-> !to_supv);
   a_r3_mach_stack: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && !to_supv |=> !mie_q && mpie_q == $past(mie_q) && mpp_q == $past(priv_q));
   a_r3_supv_stack: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && to_supv |=> !sie_q && spie_q == $past(sie_q));
   a_r4_mach_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && !to_supv |=> mcause_q[XLEN-1] == $past(trap_irq));
   a_r4_supv_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && to_supv |=> scause_q[XLEN-1] == $past(trap_irq));
   a_r5_mach_epc: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && !to_supv |=> mepc_q == $past(trap_pc));
   a_r5_supv_epc: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && to_supv |=> sepc_q == $past(trap_pc));
   a_r10_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> redirect_valid && resv_clear);
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |=> !redirect_valid && !resv_clear);
endmodule

bind trap_entry_seq trap_entry_chk #(.XLEN(XLEN)) u_trap_entry_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trap_req      (trap_req),
   .trap_irq      (trap_irq),
   .trap_pc       (trap_pc),
   .to_supv       (to_supv),
   .priv_q        (priv_q),
   .sie_q         (sie_q),
   .mie_q         (mie_q),
   .spie_q        (spie_q),
   .mpie_q        (mpie_q),
   .mpp_q         (mpp_q),
   .mepc_q        (mepc_q),
   .sepc_q        (sepc_q),
   .mcause_q      (mcause_q),
   .scause_q      (scause_q),
   .redirect_valid(redirect_valid),
   .resv_clear    (resv_clear)
);

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0;
   logic        trap_irq = 1'b0;
   logic [4:0]  trap_cause = '0;
   logic [31:0] trap_addr = '0;
   logic [31:0] trap_pc = '0;
   logic        csr_we = 1'b0;
   logic [3:0]  csr_sel = '0;
   logic [31:0] csr_wdata = '0;
   logic [3:0]  csr_rsel = '0;
   logic [31:0] csr_rdata;
   logic        redirect_valid;
   logic [31:0] redirect_pc;
   logic        resv_clear;
   logic [1:0]  cur_priv;

   trap_entry_seq u_trap_entry_seq (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
      .trap_cause(trap_cause), .trap_addr(trap_addr), .trap_pc(trap_pc),
      .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .csr_rsel(csr_rsel), .csr_rdata(csr_rdata),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .resv_clear(resv_clear), .cur_priv(cur_priv)
   );

   always #2.5 clk = ~clk;

   localparam logic [31:0] ST_MASK = 32'h0000_19AA;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] sh [0:10];
   logic [1:0]  m_priv;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string req_of(input int sel);
      case (sel)
         0:       return "R3 status";
         1, 2:    return "R12 deleg";
         3, 7:    return "R12 vector";
         4, 8:    return "R5 epc";
         5, 9:    return "R4 cause";
         6, 10:   return "R6 tval";
         default: return "R1 priv";
      endcase
   endfunction

   // readback of every selector; called with the clock low and no strobes
   task automatic verify_all(input string tag);
      for (int s = 0; s < 12; s++) begin
         csr_rsel = 4'(s);
         #0.1;
         chk({tag, "/", req_of(s)}, csr_rdata, (s == 11) ? {30'b0, m_priv} : sh[s]);
      end
      chk({tag, "/R1 priv port"}, {30'b0, cur_priv}, {30'b0, m_priv});
   endtask

   function automatic void model_write(input int sel, input logic [31:0] d);
      if (sel == 0)       sh[0] = d & ST_MASK;
      else if (sel <= 10) sh[sel] = d;
      else if (sel == 11) m_priv = (d[1:0] == 2'd2) ? 2'd0 : d[1:0];
   endfunction

   task automatic csr_write(input int sel, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_sel = 4'(sel); csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
      model_write(sel, d);
   endtask

   function automatic logic addr_kind(input int c);
      return (c inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
   endfunction

   task automatic take_trap(input string tag, input logic irq, input int cause,
                            input logic [31:0] addr, input logic [31:0] pc,
                            input logic also_we, input int wsel, input logic [31:0] wd);
      int          ec;
      logic [31:0] dm, vec, npc, st;
      logic        sup;
      ec = cause;
      if (!irq && cause == 8) ec = (m_priv == 2'd0) ? 8 : (m_priv == 2'd1) ? 9 : 11;
      dm  = irq ? sh[2] : sh[1];
      sup = (m_priv != 2'd3) && dm[ec];
      vec = sup ? sh[7] : sh[3];
      npc = {vec[31:2], 2'b00};
      if (irq && vec[1:0] == 2'b01) npc = npc + 32'(ec) * 4;
      @(negedge clk);
      trap_req = 1'b1; trap_irq = irq; trap_cause = 5'(cause);
      trap_addr = addr; trap_pc = pc;
      csr_we = also_we; csr_sel = 4'(wsel); csr_wdata = wd;
      @(posedge clk);
      #1;
      chk({tag, "/R10 redirect valid"}, {31'b0, redirect_valid}, 32'd1);
      chk({tag, "/R10 resv clear"}, {31'b0, resv_clear}, 32'd1);
      chk({tag, "/R7 R8 handler pc"}, redirect_pc, npc);
      // R11: any same-cycle write is not applied to the model
      st = sh[0];
      if (sup) begin
         st[5] = st[1]; st[8] = (m_priv != 2'd0); st[1] = 1'b0;
         sh[8] = pc; sh[9] = {irq, 26'b0, 5'(ec)}; sh[10] = (!irq && addr_kind(ec)) ? addr : 32'h0;
         m_priv = 2'd1;
      end else begin
         st[7] = st[3]; st[12:11] = m_priv; st[3] = 1'b0;
         sh[4] = pc; sh[5] = {irq, 26'b0, 5'(ec)}; sh[6] = (!irq && addr_kind(ec)) ? addr : 32'h0;
         m_priv = 2'd3;
      end
      sh[0] = st;
      @(negedge clk);
      trap_req = 1'b0; csr_we = 1'b0;
      verify_all(tag);
      @(posedge clk);
      #1;
      chk({tag, "/R10 single pulse"}, {31'b0, redirect_valid}, 32'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0005_1A7E));
      for (int i = 0; i <= 10; i++) sh[i] = '0;
      m_priv = 2'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R13 reset state
      chk("R13 redirect", {31'b0, redirect_valid}, 32'd0);
      chk("R13 resv", {31'b0, resv_clear}, 32'd0);
      chk("R13 pc", redirect_pc, 32'd0);
      verify_all("R13");

      // R8 vectored interrupt and exception
      csr_write(3, 32'h0000_0101);
      take_trap("R8 irq", 1'b1, 7, 32'h55, 32'h2000, 1'b0, 0, 0);
      take_trap("R8 exc", 1'b0, 2, 32'h66, 32'h2004, 1'b0, 0, 0);
      // R9 ecall from machine, then from user delegated, then from supervisor
      take_trap("R9 mach", 1'b0, 8, 32'h77, 32'h2008, 1'b0, 0, 0);
      csr_write(1, 32'h0000_0100);
      csr_write(7, 32'h0000_4001);
      csr_write(11, 32'd2);            // R12 value 2 selects user
      verify_all("R12 priv2");
      take_trap("R9 user", 1'b0, 8, 32'h88, 32'h3000, 1'b0, 0, 0);
      take_trap("R9 supv", 1'b0, 8, 32'h99, 32'h3004, 1'b0, 0, 0);
      // R2 interrupt uses the interrupt mask only
      csr_write(11, 32'd1);
      csr_write(0, 32'hFFFF_FFFF);
      take_trap("R2 irq undelegated", 1'b1, 8, 32'h0, 32'h3008, 1'b0, 0, 0);
      csr_write(2, 32'h0000_0020);
      csr_write(11, 32'd0);
      take_trap("R2 irq delegated", 1'b1, 5, 32'h0, 32'h300C, 1'b0, 0, 0);
      // R6 faulting address kept for a page fault
      take_trap("R6 pf", 1'b0, 13, 32'hCAFE_F00D, 32'h3010, 1'b0, 0, 0);
      // R11 same-cycle write discarded
      take_trap("R11 prio", 1'b0, 3, 32'h1, 32'h3014, 1'b1, 4, 32'hDEAD_BEEF);

      for (int k = 0; k < 400; k++) begin
         int r;
         r = int'($urandom % 4);
         if (r == 0) csr_write(int'($urandom % 13), $urandom);
         else take_trap("RND", 1'($urandom), int'($urandom % 16), $urandom, $urandom,
                        ($urandom % 5) == 0, int'($urandom % 12), $urandom);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule